// File: doc/BRIEF.md
# Input-Complete Dual-Rail Multiplexer Unit

This block computes a 2:1 selection on dual-rail operands: a select operand picks one of two data operands, and every operand travels on a pair of rails that carry either a value or an empty spacer. The result is built as a full minterm plane. Each of the eight combinations of operand values owns one hysteretic product term. A term fires only when all three of its chosen rails are high, drops only when all three are low, and otherwise keeps its state. The two result rails are ORs over the terms whose function value is TRUE or FALSE.

Because every term watches a rail of every operand, including the data operand that is not selected, the result cannot appear before the whole operand set has arrived. It also cannot return to the spacer before the whole operand set has left. Hysteresis is modelled with state flops on a sampling clock, so each term is one register. A completion flag closes the handshake. It rises once a result is present while all operands still carry values, and it falls once the result and all operands are empty.

Top module: `drmx_unit`

## Requirements
- R1: Each operand and the result use a rail pair {t, f}: FALSE is t=0,f=1; TRUE is t=1,f=0; the spacer (NULL) is t=0,f=0; t=1,f=1 never appears. After a synchronous active-low reset, both result rails and the completion flag are 0.
- R2: When all three operands carry values, the result one clock after they are sampled equals A if S is FALSE and B if S is TRUE.
- R3: Starting from an empty result, the result stays NULL while any operand pair is NULL, including the unselected data operand.
- R4: Once a result is present, it holds its value while any operand pair still carries data, including only the unselected operand. It becomes NULL one clock after all operands are NULL.
- R5: At most one result rail is high at any time.
- R6: Over one full data-then-NULL cycle of the operands, the result rails change exactly twice: one set and one clear.
- R7: The completion flag goes to 1 one clock after a result is present while all operands still carry data. It goes to 0 one clock after the result is NULL while all operands are NULL. Otherwise it holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock for the hysteretic state |
| rst_n | input | 1 | Synchronous active-low reset |
| sel_t | input | 1 | Select operand, TRUE rail |
| sel_f | input | 1 | Select operand, FALSE rail |
| da_t | input | 1 | Data operand A, TRUE rail |
| da_f | input | 1 | Data operand A, FALSE rail |
| db_t | input | 1 | Data operand B, TRUE rail |
| db_f | input | 1 | Data operand B, FALSE rail |
| y_t | output | 1 | Result, TRUE rail |
| y_f | output | 1 | Result, FALSE rail |
| done | output | 1 | Completion flag for the handshake |

## Verification
The result rails come from one register stage, so a change in operands applied between edges shows on the rails one clock later. The completion flag sits one register further on and follows one clock after the result. The bench drives the operands on the falling edge and lets exactly one rising edge pass before each sample. Its reference advances its expected result and flag with the same one-edge lag, using the operand state that was present at that edge. Operand pairs arrive and leave one at a time in random orders with random idle gaps, so every arrival and departure position is sampled. Directed waves make the unselected operand arrive last and leave last.

// File: rtl/drmx_pkg.sv
// Shared constants and the function table for the dual-rail selection unit.
// Operand index order in packed vectors: 0 = A, 1 = B, 2 = S.
package drmx_pkg;
    localparam int NUM_IN    = 3;
    localparam int NUM_TERMS = 1 << NUM_IN;

    // Function value for one operand combination (bit i of m = value of operand i).
    function automatic logic sel_eval(input logic [31:0] m);
        logic a, b, s;
        a = m[0];
        b = m[1];
        s = m[2];
        return s ? b : a;
    endfunction

    // Truth vector over all minterms, computed rather than written out.
    function automatic logic [NUM_TERMS-1:0] truth_vec();
        logic [NUM_TERMS-1:0] v;
        for (int m = 0; m < NUM_TERMS; m++) begin
            v[m] = sel_eval(32'(m));
        end
        return v;
    endfunction
endpackage

// File: rtl/drmx_th_term.sv
// One hysteretic product term: sets when every input rail is high,
// clears when every input rail is low, and holds in all other cases.
// Assumes inputs change only between clock edges (driven by operand rails).
module drmx_th_term #(
    parameter int WIDTH = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] rails,
    output logic             q
);
    // Threshold state update with hold band.
    always_ff @(posedge clk) begin
        if (!rst_n)          q <= 1'b0;
        else if (&rails)     q <= 1'b1;
        else if (~|rails)    q <= 1'b0;
    end

    // R4
    term_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q && (|rails)) |=> q);

    // R3
    term_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!q && !(&rails)) |=> !q);
endmodule

// File: rtl/drmx_and_plane.sv
// Full minterm plane: one hysteretic term per operand value combination.
// Term m takes the TRUE rail of operand i when bit i of m is 1, else the FALSE rail,
// so every term reads exactly one rail of every operand.
module drmx_and_plane #(
    parameter int N_IN    = 3,
    localparam int N_TERM = 1 << N_IN
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_IN-1:0]   op_t,
    input  logic [N_IN-1:0]   op_f,
    output logic [N_TERM-1:0] terms
);
    for (genvar m = 0; m < N_TERM; m++) begin : g_term
        logic [N_IN-1:0] pick;
        for (genvar i = 0; i < N_IN; i++) begin : g_rail
            if (((m >> i) & 1) == 1) begin : g_t
                assign pick[i] = op_t[i];
            end else begin : g_f
                assign pick[i] = op_f[i];
            end
        end
        drmx_th_term #(.WIDTH(N_IN)) u_term (
            .clk   (clk),
            .rst_n (rst_n),
            .rails (pick),
            .q     (terms[m])
        );
    end
endmodule

// File: rtl/drmx_or_plane.sv
// Output plane: each result rail is the OR of the terms whose function value matches it.
// Assumes at most one term is set at a time (valid dual-rail operands).
module drmx_or_plane #(
    parameter int N_TERM = 8,
    parameter logic [N_TERM-1:0] TRUTH = '0
) (
    input  logic [N_TERM-1:0] terms,
    output logic              res_t,
    output logic              res_f
);
    // Gather TRUE and FALSE terms onto their rails.
    always_comb begin
        res_t = |(terms & TRUTH);
        res_f = |(terms & ~TRUTH);
    end
endmodule

// File: rtl/drmx_complete.sv
// Completeness detector over a set of rail pairs: reports when every pair
// carries a value and when every pair is empty.
module drmx_complete #(
    parameter int N = 3
) (
    input  logic [N-1:0] pt,
    input  logic [N-1:0] pf,
    output logic         all_data,
    output logic         all_null
);
    // Per-pair presence reduced both ways.
    always_comb begin
        all_data = &(pt | pf);
        all_null = ~|(pt | pf);
    end
endmodule

// File: rtl/drmx_unit.sv
// Input-complete dual-rail 2:1 selector. A minterm plane of hysteretic terms
// feeds an OR plane; a completion flag closes the handshake.
// Assumes operand pairs never show t=1,f=1 and change only between clock edges.
module drmx_unit
    import drmx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sel_t,
    input  logic sel_f,
    input  logic da_t,
    input  logic da_f,
    input  logic db_t,
    input  logic db_f,
    output logic y_t,
    output logic y_f,
    output logic done
);
    localparam logic [NUM_TERMS-1:0] TRUTH = truth_vec();

    logic [NUM_IN-1:0]    op_t, op_f;
    logic [NUM_TERMS-1:0] terms;
    logic                 in_data, in_null;

    assign op_t = {sel_t, db_t, da_t};
    assign op_f = {sel_f, db_f, da_f};

    drmx_and_plane #(.N_IN(NUM_IN)) u_and (
        .clk   (clk),
        .rst_n (rst_n),
        .op_t  (op_t),
        .op_f  (op_f),
        .terms (terms)
    );

    drmx_or_plane #(.N_TERM(NUM_TERMS), .TRUTH(TRUTH)) u_or (
        .terms (terms),
        .res_t (y_t),
        .res_f (y_f)
    );

    drmx_complete #(.N(NUM_IN)) u_cmp (
        .pt       (op_t),
        .pf       (op_f),
        .all_data (in_data),
        .all_null (in_null)
    );

    // Completion flag: set on result present with full operands, clear on all empty.
    always_ff @(posedge clk) begin
        if (!rst_n)                           done <= 1'b0;
        else if ((y_t | y_f) && in_data)      done <= 1'b1;
        else if (!(y_t | y_f) && in_null)     done <= 1'b0;
    end

    // R1
    rail_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(|(op_t & op_f)));

    // R5
    out_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({y_t, y_f}));

    // R3
    null_until_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(y_t | y_f) && !in_data) |=> !(y_t | y_f));

    // R4
    hold_until_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((y_t | y_f) && !in_null) |=> $stable({y_t, y_f}));

    // R7
    done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> (y_t | y_f));
endmodule

// File: tb/drmx_unit_bench.sv
module drmx_unit_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [2:0] cur_t = '0, cur_f = '0;   // index 0 = A, 1 = B, 2 = S
    logic y_t, y_f, done;

    int tests = 0;
    int fails = 0;
    logic [1:0] exp_y = 2'b00;            // {t, f}
    logic       exp_done = 1'b0;
    logic [1:0] last_y = 2'b00;
    int         toggles = 0;
    bit         finished = 0;

    always #4 clk = ~clk;

    drmx_unit u_drmx_unit (
        .clk(clk), .rst_n(rst_n),
        .sel_t(cur_t[2]), .sel_f(cur_f[2]),
        .da_t(cur_t[0]), .da_f(cur_f[0]),
        .db_t(cur_t[1]), .db_f(cur_f[1]),
        .y_t(y_t), .y_f(y_f), .done(done)
    );

    function automatic logic [1:0] ref_sel(input logic [2:0] t);
        logic v;
        v = t[2] ? t[1] : t[0];
        return v ? 2'b10 : 2'b01;
    endfunction

    task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    // One clock: advance the reference with the operands present at the edge, then sample.
    task automatic step();
        logic ad, an;
        logic [1:0] ny;
        logic nd;
        string tag;
        ad = &(cur_t | cur_f);
        an = ~|(cur_t | cur_f);
        nd = exp_done;
        if (exp_y != 2'b00 && ad) nd = 1'b1;
        else if (exp_y == 2'b00 && an) nd = 1'b0;
        ny = exp_y;
        if (ad && exp_y == 2'b00) ny = ref_sel(cur_t);
        else if (an) ny = 2'b00;
        @(posedge clk);
        @(negedge clk);
        exp_y = ny;
        exp_done = nd;
        if (ad) tag = "R2";
        else if (exp_y == 2'b00) tag = "R3";
        else tag = "R4";
        check(tag, {y_t, y_f}, exp_y);
        check("R7", {1'b0, done}, {1'b0, exp_done});
        check("R5", {1'b0, !(y_t && y_f)}, 2'b01);
        if ({y_t, y_f} != last_y) toggles++;
        last_y = {y_t, y_f};
    endtask

    task automatic idle_gap();
        int n = int'($urandom % 3);
        for (int k = 0; k < n; k++) step();
    endtask

    // Full data-then-NULL wave with given arrival and departure orders.
    task automatic wave(input logic [2:0] vals, input int up0, input int up1, input int up2,
                        input int dn0, input int dn1, input int dn2);
        int up[3];
        int dn[3];
        up[0] = up0; up[1] = up1; up[2] = up2;
        dn[0] = dn0; dn[1] = dn1; dn[2] = dn2;
        toggles = 0;
        for (int k = 0; k < 3; k++) begin
            cur_t[up[k]] = vals[up[k]];
            cur_f[up[k]] = ~vals[up[k]];
            step();
            idle_gap();
        end
        step();
        step();
        for (int k = 0; k < 3; k++) begin
            cur_t[dn[k]] = 1'b0;
            cur_f[dn[k]] = 1'b0;
            step();
            idle_gap();
        end
        step();
        step();
        check("R6", 2'(toggles), 2'd2);
    endtask

    task automatic perm(output int p0, output int p1, output int p2);
        case ($urandom % 6)
            0: begin p0 = 0; p1 = 1; p2 = 2; end
            1: begin p0 = 0; p1 = 2; p2 = 1; end
            2: begin p0 = 1; p1 = 0; p2 = 2; end
            3: begin p0 = 1; p1 = 2; p2 = 0; end
            4: begin p0 = 2; p1 = 0; p2 = 1; end
            default: begin p0 = 2; p1 = 1; p2 = 0; end
        endcase
    endtask

    initial begin
        int a0, a1, a2, d0, d1, d2;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1", {y_t, y_f}, 2'b00);
        check("R1", {1'b0, done}, 2'b00);
        step();
        // Directed: S FALSE selects A=TRUE; unselected B arrives last and leaves last (R3, R4)
        wave(3'b001, 2, 0, 1, 2, 0, 1);
        // Directed: S TRUE selects B=FALSE; unselected A arrives last and leaves last
        wave(3'b101, 2, 1, 0, 1, 2, 0);
        // Directed: every combination once, select last in and first out
        for (int v = 0; v < 8; v++) wave(3'(v), 0, 1, 2, 2, 0, 1);
        // Random waves
        for (int n = 0; n < 60; n++) begin
            perm(a0, a1, a2);
            perm(d0, d1, d2);
            wave(3'($urandom % 8), a0, a1, a2, d0, d1, d2);
        end
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule